// File: doc/BRIEF.md
# Dual-Mode Serial Converter Frame Interface

This block is the digital front end of an eight-input, 10-bit sampling converter. A host talks to it over a chip-select line, a serial clock, a data-in line, a data-out line and an optional frame-sync line. All of these are brought into the system clock domain through a synchronizer and edge-detected there. When chip-select falls, the level of frame sync picks the framing style. A low level selects DSP framing, where every frame is opened by frame sync being low on a serial-clock falling edge. A high level selects microcontroller framing, where frames of 16 serial clocks follow one another with no gap, starting at chip-select.

Each frame carries a 16-bit control word in, MSB first. That word becomes the active configuration for the next frame, which drives the input multiplexer, the self-test select, the reference and power options, and the sample window. The block captures the 10-bit converter result at the end of each converting frame and shifts it out during the frame after that. A read-back bit replaces the result with the active register contents. An auto-scan sequencer steps through one of four channel orders, one step per frame.

Top module: `conv_serial_port`

## Requirements
- R1: At the chip-select falling edge the block latches the mode: frame sync low gives DSP mode (dsp_mode=1), high gives microcontroller mode (dsp_mode=0). The mode holds until chip-select rises again.
- R2: While chip-select is high, sdout_oe is 0, pwr_dn is 1, and the configuration and result pipeline are cleared.
- R3: A frame is 16 serial-clock rising edges, and each edge captures one data-in bit, MSB first. In microcontroller mode frames run back to back from the chip-select fall. In DSP mode a frame opens at the first serial-clock falling edge that sees frame sync low while no frame is open. Frame sync low inside an open frame has no effect.
- R4: Data-out is launched on serial-clock falling edges, MSB first. The first bit is valid before the first rising edge of the frame.
- R5: A word received in frame N controls frame N+1. The field outputs map as follows: bit 11 to low_speed, bit 6 to int_ref, bit 5 to ref_hi, bit 4 to auto_pd_en, bit 3 to low_supply. All field outputs are 0 while no word is active.
- R6: Bits 13:12 drive test_sel: 00 is normal input, 01 is ground, 10 is half reference. Code 11 is output as 00.
- R7: The result word of a frame is {result[9:0], 6'b0}. The value is the adc_result captured at the end of the previous frame, provided that frame converted. Otherwise the word is all zeros. For this reason the first two frames after chip-select falls return zeros.
- R8: Bit 15 set is software power-down. In the frame where it is active, pwr_dn is 1, no sample window occurs and no conversion runs, so the next frame returns zeros.
- R9: Bit 14 set is read-back. The frame where it is active returns {register[15:1], 1'b0} in place of a result.
- R10: Bits 2:0 are reserved. Ones written to them are dropped and read back as 0.
- R11: With bit 10 clear, mux_ch equals bits 9:7.
- R12: With bit 10 set, bits 9:8 pick an order: 00 is 0..7, 01 is 1,3,5,7, 10 is 0,2,4,6, 11 is 7..0. The order restarts at its first channel when bit 7 is set, when the order changes, or when the previous frame was not scanning. Otherwise it advances one step and wraps at the end.
- R13: sample_win is high from the start of a converting frame until its 6th serial-clock rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| fs | input | 1 | Frame sync; held high in microcontroller mode |
| sdin | input | 1 | Serial control word in |
| adc_result | input | RES_BITS | Conversion result from the converter core |
| sdout | output | 1 | Serial data out |
| sdout_oe | output | 1 | Output enable for sdout |
| dsp_mode | output | 1 | Latched framing mode |
| sample_win | output | 1 | Input sampling window |
| pwr_dn | output | 1 | Converter power-down request |
| mux_ch | output | 3 | Selected analog channel |
| test_sel | output | 2 | Self-test input select |
| low_speed | output | 1 | Low-speed mode |
| int_ref | output | 1 | Internal reference select |
| ref_hi | output | 1 | Higher internal reference level |
| auto_pd_en | output | 1 | Auto power-down enable |
| low_supply | output | 1 | Low-supply linearity option |

## Verification
The bench builds the block with its default parameters: a 10-bit result, a 6-clock sample window and a two-stage synchronizer. The serial clock runs at sixteen system clocks per period, so every synchronizer and phase-step delay settles well inside a half period. With this small setup the bench can sweep all eight manual channels and all four self-test codes. It can also run every scan order through a complete wrap, including order changes in the middle and restarts. Both framing modes are covered, with a frame-sync glitch inside an open DSP frame. The bench predicts each returned word from a two-frame model of the configuration pipeline.

// File: rtl/csp_pkg.sv
package csp_pkg;

    localparam int WORD_W = 16;
    localparam int CH_W   = 3;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_WAIT  = 3'd1,
        PH_LOAD  = 3'd2,
        PH_SHIFT = 3'd3,
        PH_DONE  = 3'd4
    } phase_e;

    // Field layout of the 16-bit control word, MSB first.
    typedef struct packed {
        logic            pd;       // 15 software power-down
        logic            rdbk;     // 14 register read-back
        logic [1:0]      tsel;     // 13:12 self-test input
        logic            low_spd;  // 11
        logic            scan_en;  // 10
        logic [CH_W-1:0] chf;      // 9:7 channel, or order + restart
        logic            int_ref;  // 6
        logic            ref_hi;   // 5
        logic            auto_pd;  // 4
        logic            low_sup;  // 3
        logic [2:0]      rsvd;     // 2:0
    } ctl_word_t;

    function automatic ctl_word_t clean_word(input logic [WORD_W-1:0] w);
        ctl_word_t c;
        c      = ctl_word_t'(w);
        c.rsvd = 3'b000;
        return c;
    endfunction

    function automatic logic [CH_W-1:0] scan_channel(input logic [1:0] order,
                                                     input logic [CH_W-1:0] pos);
        logic [CH_W-1:0] ch;
        case (order)
            2'b00:   ch = pos;
            2'b01:   ch = {pos[1:0], 1'b1};
            2'b10:   ch = {pos[1:0], 1'b0};
            default: ch = ~pos;
        endcase
        return ch;
    endfunction

    function automatic logic [CH_W-1:0] scan_wrap_mask(input logic [1:0] order);
        return (order == 2'b01 || order == 2'b10) ? CH_W'(3) : CH_W'(7);
    endfunction

endpackage

// File: rtl/csp_sync.sv
module csp_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl
);

    logic [WIDTH-1:0] pipe_d [STAGES];
    logic [WIDTH-1:0] pipe_q [STAGES];

    always_comb begin
        pipe_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
        end else begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= pipe_d[s];
        end
    end

    assign lvl = pipe_q[STAGES-1];

endmodule

// File: rtl/csp_frame.sv
module csp_frame
    import csp_pkg::*;
#(
    parameter int FRAME_BITS   = 16,
    parameter int SAMPLE_SCLKS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n_s,
    input  logic                  sclk_s,
    input  logic                  fs_s,
    input  logic                  sdin_s,
    input  logic [FRAME_BITS-1:0] tx_word,
    input  logic                  conv_active,
    output logic                  cs_on,
    output logic                  dsp_mode,
    output logic                  done,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic                  sdout,
    output logic                  sample_win
);

    localparam int CNT_W = $clog2(FRAME_BITS + 1);

    typedef struct packed {
        phase_e                phase;
        logic [CNT_W-1:0]      cnt;
        logic                  dsp;
        logic [FRAME_BITS-1:0] rx;
        logic [FRAME_BITS-1:0] tx;
        logic                  done;
        logic                  sclk_p;
        logic                  cs_p;
    } fr_t;

    fr_t  q, d;
    logic sclk_rise, sclk_fall, cs_fall;

    always_comb begin
        sclk_rise = sclk_s & ~q.sclk_p;
        sclk_fall = ~sclk_s & q.sclk_p;
        cs_fall   = q.cs_p & ~cs_n_s;
    end

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.sclk_p = sclk_s;
        d.cs_p   = cs_n_s;
        if (cs_n_s) begin
            d.phase = PH_IDLE;
            d.cnt   = '0;
        end else begin
            case (q.phase)
                PH_IDLE: begin
                    if (cs_fall) begin
                        d.dsp   = ~fs_s;
                        d.phase = fs_s ? PH_LOAD : PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    if (sclk_fall && !fs_s) d.phase = PH_LOAD;
                end
                PH_LOAD: begin
                    d.tx    = tx_word;
                    d.cnt   = '0;
                    d.phase = PH_SHIFT;
                end
                PH_SHIFT: begin
                    if (sclk_rise) begin
                        d.rx  = {q.rx[FRAME_BITS-2:0], sdin_s};
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == CNT_W'(FRAME_BITS - 1)) begin
                            d.done  = 1'b1;
                            d.phase = PH_DONE;
                        end
                    end else if (sclk_fall && q.cnt != '0) begin
                        d.tx = {q.tx[FRAME_BITS-2:0], 1'b0};
                    end
                end
                PH_DONE: begin
                    d.phase = q.dsp ? PH_WAIT : PH_LOAD;
                end
                default: d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, cnt: '0, dsp: 1'b0, rx: '0, tx: '0,
                   done: 1'b0, sclk_p: 1'b0, cs_p: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign cs_on      = ~cs_n_s;
    assign dsp_mode   = q.dsp;
    assign done       = q.done;
    assign rx_word    = q.rx;
    assign sdout      = q.tx[FRAME_BITS-1];
    assign sample_win = (q.phase == PH_SHIFT) && (q.cnt < CNT_W'(SAMPLE_SCLKS)) && conv_active;

    logic   in_frame_q;
    phase_e phase_q;
    assign phase_q    = q.phase;
    assign in_frame_q = (q.phase != PH_IDLE);

    // Mode never changes while chip select stays low.
    assert_mode_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_on && $past(cs_on) && in_frame_q && $past(in_frame_q)) |-> $stable(dsp_mode))
        else $error("mode changed inside a select period");

    // Bit counter never passes one full frame.
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(FRAME_BITS))
        else $error("bit counter overran the frame");

    // Frame completion is a single-cycle event followed by the done phase.
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (phase_q == PH_DONE || !cs_on) ##1 !done)
        else $error("frame done not a single pulse");

endmodule

// File: rtl/csp_scan.sv
module csp_scan
    import csp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            apply,
    input  logic            scan_en,
    input  logic [1:0]      order,
    input  logic            restart,
    input  logic [CH_W-1:0] man_ch,
    output logic [CH_W-1:0] ch
);

    typedef struct packed {
        logic [CH_W-1:0] pos;
        logic [1:0]      order;
        logic            on;
        logic [CH_W-1:0] ch;
    } scan_t;

    scan_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d = '0;
        end else if (apply) begin
            if (scan_en) begin
                if (restart || !q.on || order != q.order) begin
                    d.pos = '0;
                end else begin
                    d.pos = (q.pos + 1'b1) & scan_wrap_mask(order);
                end
                d.order = order;
                d.on    = 1'b1;
                d.ch    = scan_channel(order, d.pos);
            end else begin
                d.on = 1'b0;
                d.ch = man_ch;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ch = q.ch;

    // Odd-only order always lands on an odd input.
    assert_odd_order_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.on && q.order == 2'b01) |-> ch[0])
        else $error("odd order selected an even input");

    // Even-only order always lands on an even input.
    assert_even_order_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.on && q.order == 2'b10) |-> !ch[0])
        else $error("even order selected an odd input");

endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port
    import csp_pkg::*;
#(
    parameter int RES_BITS     = 10,
    parameter int SAMPLE_SCLKS = 6,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                fs,
    input  logic                sdin,
    input  logic [RES_BITS-1:0] adc_result,
    output logic                sdout,
    output logic                sdout_oe,
    output logic                dsp_mode,
    output logic                sample_win,
    output logic                pwr_dn,
    output logic [CH_W-1:0]     mux_ch,
    output logic [1:0]          test_sel,
    output logic                low_speed,
    output logic                int_ref,
    output logic                ref_hi,
    output logic                auto_pd_en,
    output logic                low_supply
);

    localparam int PAD_W = WORD_W - RES_BITS;

    typedef struct packed {
        ctl_word_t           raw;
        logic                ok;
        logic [RES_BITS-1:0] res;
        logic                res_ok;
    } top_t;

    top_t            q, d;
    logic [3:0]      sync_lvl;
    logic            cs_on, fr_done, fr_sdout, conv_active;
    logic [WORD_W-1:0] rx_word, tx_word, raw_bits;
    ctl_word_t       rx_c;
    logic [CH_W-1:0] scan_ch;

    csp_sync #(
        .WIDTH  (4),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b1010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, sclk, fs, sdin}),
        .lvl  (sync_lvl)
    );

    csp_frame #(
        .FRAME_BITS  (WORD_W),
        .SAMPLE_SCLKS(SAMPLE_SCLKS)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_s     (sync_lvl[3]),
        .sclk_s     (sync_lvl[2]),
        .fs_s       (sync_lvl[1]),
        .sdin_s     (sync_lvl[0]),
        .tx_word    (tx_word),
        .conv_active(conv_active),
        .cs_on      (cs_on),
        .dsp_mode   (dsp_mode),
        .done       (fr_done),
        .rx_word    (rx_word),
        .sdout      (fr_sdout),
        .sample_win (sample_win)
    );

    assign rx_c = clean_word(rx_word);

    csp_scan u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (~cs_on),
        .apply  (fr_done),
        .scan_en(rx_c.scan_en),
        .order  (rx_c.chf[2:1]),
        .restart(rx_c.chf[0]),
        .man_ch (rx_c.chf),
        .ch     (scan_ch)
    );

    assign raw_bits    = q.raw;
    assign conv_active = q.ok & ~q.raw.pd;

    always_comb begin
        if (q.ok && q.raw.rdbk)  tx_word = {raw_bits[WORD_W-1:1], 1'b0};
        else if (q.res_ok)       tx_word = WORD_W'(q.res) << PAD_W;
        else                     tx_word = '0;
    end

    always_comb begin
        d = q;
        if (!cs_on) begin
            d.ok     = 1'b0;
            d.res_ok = 1'b0;
            d.raw    = '0;
        end else if (fr_done) begin
            d.res    = adc_result;
            d.res_ok = conv_active;
            d.raw    = rx_c;
            d.ok     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdout      = cs_on ? fr_sdout : 1'b0;
    assign sdout_oe   = cs_on;
    assign pwr_dn     = ~cs_on | (q.ok & q.raw.pd);
    assign mux_ch     = q.ok ? scan_ch : '0;
    assign test_sel   = (q.ok && q.raw.tsel != 2'b11) ? q.raw.tsel : 2'b00;
    assign low_speed  = q.ok & q.raw.low_spd;
    assign int_ref    = q.ok & q.raw.int_ref;
    assign ref_hi     = q.ok & q.raw.ref_hi;
    assign auto_pd_en = q.ok & q.raw.auto_pd;
    assign low_supply = q.ok & q.raw.low_sup;

    // Deselect empties the configuration pipeline on the next cycle.
    assert_clear_on_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_on |=> (!q.ok && !q.res_ok))
        else $error("pipeline not cleared while deselected");

    // Reserved bits never survive into the register.
    assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q.ok |-> (raw_bits[2:0] == 3'b000))
        else $error("reserved bits stored");

    // A powered-down frame never opens a sample window.
    assert_pd_no_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ok && q.raw.pd) |-> !sample_win)
        else $error("sample window during software power-down");

endmodule

// File: tb/conv_serial_port_tb.sv
module conv_serial_port_tb;

    localparam int HP = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sclk = 1'b0, fs = 1'b1, sdin = 1'b0;
    logic [9:0] adc_result = '0;
    logic       sdout, sdout_oe, dsp_mode, sample_win, pwr_dn;
    logic [2:0] mux_ch;
    logic [1:0] test_sel;
    logic       low_speed, int_ref, ref_hi, auto_pd_en, low_supply;

    conv_serial_port u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .fs(fs), .sdin(sdin),
        .adc_result(adc_result), .sdout(sdout), .sdout_oe(sdout_oe),
        .dsp_mode(dsp_mode), .sample_win(sample_win), .pwr_dn(pwr_dn),
        .mux_ch(mux_ch), .test_sel(test_sel), .low_speed(low_speed),
        .int_ref(int_ref), .ref_hi(ref_hi), .auto_pd_en(auto_pd_en),
        .low_supply(low_supply)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // Model of the two-frame pipeline.
    logic [15:0] app_m = '0;
    logic        ok_m = 0, res_ok_m = 0, scan_m = 0;
    logic [9:0]  res_m = '0;
    logic [1:0]  ord_m = '0;
    logic [2:0]  pos_m = '0, ch_m = '0;
    int          frame_no = 0;

    task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_start(input logic fsval);
        cs_n = 1'b1;
        idle(4 * HP);
        chk(sdout_oe == 1'b0 && pwr_dn == 1'b1, "R2 deselected outputs",
            {sdout_oe, pwr_dn}, 2'b01);
        fs = fsval;
        idle(HP);
        cs_n = 1'b0;
        idle(2 * HP);
        chk(dsp_mode == ~fsval, "R1 mode latch", dsp_mode, ~fsval);
        chk(sdout_oe == 1'b1, "R2 output enabled when selected", sdout_oe, 1);
        if (!fsval) fs = 1'b1;
        ok_m = 0; res_ok_m = 0; scan_m = 0;
    endtask

    task automatic xfer(input logic [15:0] w, input logic dsp, input logic glitch, input string tag);
        logic [15:0] exp_tx, got;
        logic [10:0] exp_f, act_f;
        logic        conv, exp_win;
        logic [9:0]  adc_v;
        logic [2:0]  mask;
        frame_no++;
        adc_v = 10'((frame_no * 37 + 5) % 1024);
        adc_result = adc_v;
        conv = ok_m & ~app_m[15];
        if (ok_m && app_m[14])  exp_tx = {app_m[15:1], 1'b0};
        else if (res_ok_m)      exp_tx = {res_m, 6'b000000};
        else                    exp_tx = 16'h0000;
        if (ok_m)
            exp_f = {app_m[15], (app_m[13:12] == 2'b11) ? 2'b00 : app_m[13:12],
                     app_m[11], app_m[6], app_m[5], app_m[4], app_m[3], ch_m};
        else
            exp_f = 11'h000;
        got = '0;
        if (dsp) begin
            sclk = 1'b1; idle(HP);
            fs = 1'b0;   idle(HP);
            sclk = 1'b0;
        end
        for (int i = 0; i < 16; i++) begin
            sdin = w[15-i];
            if (dsp && i == 1) fs = 1'b1;
            if (glitch && i == 8) fs = 1'b0;
            if (glitch && i == 10) fs = 1'b1;
            idle(HP);
            got[15-i] = sdout;
            exp_win = conv && (i < 6);
            chk(sample_win == exp_win, "R13 R8 sample window", sample_win, exp_win);
            if (i == 0) begin
                act_f = {pwr_dn, test_sel, low_speed, int_ref, ref_hi, auto_pd_en, low_supply, mux_ch};
                chk(act_f == exp_f, "R5 R6 R8 R11 R12 field outputs", act_f, exp_f);
            end
            sclk = 1'b1; idle(HP);
            sclk = 1'b0;
        end
        idle(HP);
        chk(got == exp_tx, tag, got, exp_tx);
        // model update
        res_ok_m = conv;
        res_m    = adc_v;
        app_m    = w & 16'hFFF8;
        ok_m     = 1'b1;
        if (w[10]) begin
            mask = (w[9:8] == 2'b01 || w[9:8] == 2'b10) ? 3'd3 : 3'd7;
            if (w[7] || !scan_m || w[9:8] != ord_m) pos_m = 3'd0;
            else pos_m = (pos_m + 3'd1) & mask;
            ord_m = w[9:8];
            case (ord_m)
                2'b00: ch_m = pos_m;
                2'b01: ch_m = 3'(2 * pos_m + 1);
                2'b10: ch_m = 3'(2 * pos_m);
                default: ch_m = 3'(7 - pos_m);
            endcase
            scan_m = 1'b1;
        end else begin
            ch_m = w[9:7];
            scan_m = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        idle(4);
        chk(sdout_oe == 1'b0 && pwr_dn == 1'b1 && mux_ch == 3'd0, "R2 reset state",
            {sdout_oe, pwr_dn, mux_ch}, 5'b01000);
        rst_n = 1'b1;
        idle(4);

        // Microcontroller framing
        cs_start(1'b1);
        xfer(16'h0040, 0, 0, "R7 first frame returns zeros");
        xfer(16'h01C0, 0, 0, "R7 second frame returns zeros");
        for (int c = 0; c < 8; c++) begin
            xfer(16'(c << 7) | 16'(((c * 5) & 15) << 3) | 16'((c & 1) << 11), 0, 0,
                 "R4 R7 R11 result word");
        end
        for (int t = 0; t < 4; t++) begin
            xfer(16'(t << 12) | 16'h0100, 0, 0, "R6 R7 result word");
        end
        xfer(16'h4A57, 0, 0, "R7 result before read-back");
        xfer(16'h0000, 0, 0, "R9 R10 read-back word");
        xfer(16'h0000, 0, 0, "R7 result after read-back");
        xfer(16'h8000, 0, 0, "R7 result before power-down");
        xfer(16'h0000, 0, 0, "R8 power-down frame word");
        xfer(16'h0000, 0, 0, "R8 zeros after power-down");
        xfer(16'h0480, 0, 0, "R12 scan restart");
        xfer(16'h0480, 0, 0, "R12 scan restart");
        for (int k = 0; k < 10; k++) xfer(16'h0400, 0, 0, "R12 ascending order");
        for (int k = 0; k < 9; k++)  xfer(16'h0700, 0, 0, "R12 descending order");
        for (int k = 0; k < 5; k++)  xfer(16'h0500, 0, 0, "R12 odd order");
        for (int k = 0; k < 5; k++)  xfer(16'h0600, 0, 0, "R12 even order");
        xfer(16'h0480, 0, 0, "R12 mid-order restart");
        xfer(16'h0400, 0, 0, "R12 after restart");
        xfer(16'h0400, 0, 0, "R12 after restart");

        // DSP framing
        cs_start(1'b0);
        xfer(16'h0180, 1, 0, "R3 R7 dsp first frame");
        xfer(16'h0200, 1, 1, "R3 frame sync glitch ignored");
        for (int c = 0; c < 8; c++) begin
            xfer(16'(c << 7) | 16'((7 - c) << 3), 1, (c == 3), "R3 R4 R11 dsp result word");
        end
        xfer(16'h0780, 1, 0, "R12 dsp descending restart");
        for (int k = 0; k < 3; k++) xfer(16'h0700, 1, 0, "R12 dsp descending order");

        cs_n = 1'b1;
        idle(4 * HP);
        chk(sdout_oe == 1'b0 && pwr_dn == 1'b1 && mux_ch == 3'd0, "R2 after deselect",
            {sdout_oe, pwr_dn, mux_ch}, 5'b01000);
        finish_run();
    end

endmodule